// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches an SDRAM command bus and samples it on every rising clock edge. It turns the clock-enable, chip-select, row/column strobe, write-enable, bank-select and auto-precharge address bit into one decoded command. It keeps a state machine for each bank and judges each command against the state of the bank it targets. A command that is not allowed in that state is flagged and has no effect on any bank.

A memory controller or a protocol monitor can sit beside it. The registered outputs give the last decoded command, a one-cycle illegal pulse, a sticky error flag with the code of the most recent violation, one-cycle pulses for auto-precharge and precharge-all requests, a device-busy flag, and the packed per-bank states. All timing values (row-to-column delay, precharge time, refresh cycle, bank-to-bank activate spacing, mode-register delay, burst length) are parameters counted in clocks.

Every output is a register that updates on the clock edge where the command is sampled. Each timing parameter must be at least 2, except the activate spacing, which must be at least 1.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_o` gives the command sampled at the last edge. When the previous-cycle clock enable was low, it reads 10 (suspend) and the inputs are ignored. Otherwise, when chip select is high, it reads 1 (deselect) and the inputs are ignored. Otherwise {ras,cas,we} decodes as follows: 000 gives 2 (mode set), 001 gives refresh, 010 gives 5 (precharge), 011 gives 6 (activate), 100 gives 7 (write), 101 gives 8 (read), 110 gives 9 (burst stop) and 111 gives 0 (no-op).
- R2: A refresh command reads 3 (auto refresh) when clock enable is high in the sampling cycle, and 4 (self-refresh entry) when it is low. Either one holds `busy_o` high so that the next command is allowed exactly T_RC cycles later.
- R3: An activate to an idle bank makes its state 1 (opening). The state becomes 2 (active) so that a column command T_RCD cycles after the activate is legal. An activate to a bank that is not idle is illegal with code 3.
- R4: A read or write to a bank in state 2, 3 or 4 starts a burst, with state 3 for a read and 4 for a write. The bank returns to 2 so that a command BURST_LEN cycles later sees it active. A read or write to a bank in state 0, 1 or 5 is illegal with code 2.
- R5: A legal read or write with the auto-precharge bit high pulses `auto_pre_o`. At the end of the burst the bank goes to state 5 (closing), and it is idle T_RP cycles later.
- R6: A precharge with the auto-precharge bit low closes only the selected bank. With the bit high it closes every bank in state 2, 3 or 4 and pulses `pre_all_o`. A closed bank reaches state 0 so that a command T_RP cycles after the precharge sees it idle.
- R7: Mode set and refresh are illegal with code 1 unless every bank is idle. While `busy_o` is high (T_MRD cycles after a mode set, T_RC cycles after a refresh), every command other than no-op, burst stop and deselect is illegal with code 6.
- R8: A read or write to a bank that is mid-burst restarts the burst count from that command. A read or write to another bank ends the burst that is running.
- R9: While a bank runs a burst with auto-precharge, a read, write or precharge to that bank is illegal with code 4. A burst stop is also illegal with code 4.
- R10: An activate sooner than T_RRD cycles after the previous legal activate is illegal with code 5.
- R11: An illegal command pulses `illegal_o`, sets `err_o` until reset, loads its code into `err_code_o`, and changes no bank state. Running timers still advance.
- R12: A precharge that targets a bank in state 1 is illegal with code 7. So is a precharge-all while any bank is in state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; bus sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable from the bus |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank select |
| ap_i | input | 1 | Auto-precharge / all-banks address bit |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | Pulse: last command was illegal |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 3 | Code of the most recent illegal command |
| auto_pre_o | output | 1 | Pulse: legal read/write with auto-precharge |
| pre_all_o | output | 1 | Pulse: legal precharge of all banks |
| busy_o | output | 1 | Mode-set or refresh delay running |
| bank_state_o | output | NUM_BANKS*3 | Per-bank state, bank n at bits 3n+2:3n |

## Verification
The bound checker tests some properties on every cycle. The error flag stays set once raised, and an illegal pulse always comes with the flag and a nonzero code. No bank is open while the device is busy, and a precharge-all leaves no bank active. An idle bank can only move to opening, and a suspended cycle is never flagged. The exact cycle counts cannot be checked that way and are left to the bench scenarios: opening-to-active, burst end, burst restart, auto-precharge close, refresh busy windows and activate spacing. The same holds for the error-code priority and for the proof that rejected commands leave bank state untouched.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int CMD_W = 4;
  localparam int ST_W  = 3;
  localparam int ERR_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP, CMD_DESEL, CMD_MRS, CMD_AREF, CMD_SREF, CMD_PRE,
    CMD_ACT, CMD_WR, CMD_RD, CMD_BST, CMD_SUSP
  } cmd_e;

  typedef enum logic [ST_W-1:0] {
    BK_IDLE, BK_OPENING, BK_ACTIVE, BK_READ, BK_WRITE, BK_CLOSING
  } bank_st_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE, ERR_NOT_QUIET, ERR_BANK_SHUT, ERR_BANK_OPEN,
    ERR_AP_LOCK, ERR_RRD, ERR_BUSY, ERR_OPENING
  } err_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_prev_i)  cmd_o = CMD_SUSP;
    else if (cs_ni)   cmd_o = CMD_DESEL;
    else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
        3'b010:  cmd_o = CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_rules.sv
module sdram_cmd_rules
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 ap_i,
  input  bank_st_e             st_i [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] ap_burst_i,
  input  logic                 busy_i,
  input  logic                 rrd_ok_i,
  output err_e                 err_o,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [NUM_BANKS-1:0] rd_o,
  output logic [NUM_BANKS-1:0] wr_o,
  output logic [NUM_BANKS-1:0] pre_o,
  output logic [NUM_BANKS-1:0] term_o
);
  logic [NUM_BANKS-1:0] burst, live, sel;
  logic all_idle, any_open, any_ap;
  bank_st_e tgt;
  logic tgt_ap, tgt_live;

  always_comb begin
    all_idle = 1'b1;
    any_open = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      burst[i] = (st_i[i] == BK_READ) || (st_i[i] == BK_WRITE);
      live[i]  = burst[i] || (st_i[i] == BK_ACTIVE);
      sel[i]   = (ba_i == BA_W'(i));
      if (st_i[i] != BK_IDLE)    all_idle = 1'b0;
      if (st_i[i] == BK_OPENING) any_open = 1'b1;
    end
    any_ap   = |ap_burst_i;
    tgt      = st_i[ba_i];
    tgt_ap   = ap_burst_i[ba_i];
    tgt_live = live[ba_i];
  end

  // busy first, then auto-precharge lock, then per-bank state
  always_comb begin
    err_o = ERR_NONE;
    case (cmd_i)
      CMD_MRS, CMD_AREF, CMD_SREF: begin
        if (busy_i)         err_o = ERR_BUSY;
        else if (!all_idle) err_o = ERR_NOT_QUIET;
      end
      CMD_ACT: begin
        if (busy_i)               err_o = ERR_BUSY;
        else if (tgt != BK_IDLE)  err_o = ERR_BANK_OPEN;
        else if (!rrd_ok_i)       err_o = ERR_RRD;
      end
      CMD_RD, CMD_WR: begin
        if (busy_i)         err_o = ERR_BUSY;
        else if (tgt_ap)    err_o = ERR_AP_LOCK;
        else if (!tgt_live) err_o = ERR_BANK_SHUT;
      end
      CMD_PRE: begin
        if (busy_i)                       err_o = ERR_BUSY;
        else if (ap_i ? any_ap : tgt_ap)  err_o = ERR_AP_LOCK;
        else if (ap_i ? any_open : (tgt == BK_OPENING)) err_o = ERR_OPENING;
      end
      CMD_BST: if (any_ap) err_o = ERR_AP_LOCK;
      default: err_o = ERR_NONE;
    endcase
  end

  always_comb begin
    act_o  = '0;
    rd_o   = '0;
    wr_o   = '0;
    pre_o  = '0;
    term_o = '0;
    if (err_o == ERR_NONE) begin
      case (cmd_i)
        CMD_ACT: act_o = sel;
        CMD_RD:  begin rd_o = sel; term_o = burst & ~sel; end
        CMD_WR:  begin wr_o = sel; term_o = burst & ~sel; end
        CMD_PRE: pre_o = live & (ap_i ? '1 : sel);
        CMD_BST: term_o = burst;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rd_i,
  input  logic     wr_i,
  input  logic     pre_i,
  input  logic     term_i,
  input  logic     ap_i,
  output bank_st_e st_o,
  output logic     ap_burst_o
);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] BL_LD  = CNT_W'(BURST_LEN - 1);

  bank_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;

  // timed states leave on the edge where cnt_q <= 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (act_i) begin
      st_q  <= BK_OPENING;
      cnt_q <= RCD_LD;
    end else if (rd_i || wr_i) begin
      st_q  <= rd_i ? BK_READ : BK_WRITE;
      cnt_q <= BL_LD;
      ap_q  <= ap_i;
    end else if (pre_i || (term_i && ap_q)) begin
      st_q  <= BK_CLOSING;
      cnt_q <= RP_LD;
      ap_q  <= 1'b0;
    end else if (term_i) begin
      st_q <= BK_ACTIVE;
    end else begin
      case (st_q)
        BK_OPENING:
          if (cnt_q <= 1) st_q <= BK_ACTIVE;
          else            cnt_q <= cnt_q - 1'b1;
        BK_READ, BK_WRITE:
          if (cnt_q > 1) cnt_q <= cnt_q - 1'b1;
          else if (ap_q) begin
            st_q  <= BK_CLOSING;
            cnt_q <= RP_LD;
            ap_q  <= 1'b0;
          end else st_q <= BK_ACTIVE;
        BK_CLOSING:
          if (cnt_q <= 1) st_q <= BK_IDLE;
          else            cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign st_o       = st_q;
  assign ap_burst_o = ap_q;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cke_i,
  input  logic                      cs_ni,
  input  logic                      ras_ni,
  input  logic                      cas_ni,
  input  logic                      we_ni,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      ap_i,
  output logic [CMD_W-1:0]          cmd_o,
  output logic                      illegal_o,
  output logic                      err_o,
  output logic [ERR_W-1:0]          err_code_o,
  output logic                      auto_pre_o,
  output logic                      pre_all_o,
  output logic                      busy_o,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o
);
  localparam int T_MAX = max2(max2(max2(T_RC, T_RCD), max2(T_RP, BURST_LEN)),
                              max2(T_RRD, T_MRD));
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             cke_q;
  cmd_e             cmd;
  err_e             err;
  logic             legal;
  logic [CNT_W-1:0] busy_cnt, rrd_cnt;
  bank_st_e         bank_st [NUM_BANKS];
  logic [NUM_BANKS-1:0] ap_burst, act, rd, wr, pre, term;

  cmd_e cmd_q;
  err_e code_q;
  logic ill_q, err_q, apf_q, paf_q;

  sdram_cmd_decode u_dec (
    .cke_prev_i(cke_q), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  sdram_cmd_rules #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_rules (
    .cmd_i(cmd), .ba_i(ba_i), .ap_i(ap_i), .st_i(bank_st),
    .ap_burst_i(ap_burst), .busy_i(busy_cnt != '0), .rrd_ok_i(rrd_cnt == '0),
    .err_o(err), .act_o(act), .rd_o(rd), .wr_o(wr), .pre_o(pre), .term_o(term)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_fsm #(
      .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act[g]), .rd_i(rd[g]),
      .wr_i(wr[g]), .pre_i(pre[g]), .term_i(term[g]), .ap_i(ap_i),
      .st_o(bank_st[g]), .ap_burst_o(ap_burst[g])
    );
    assign bank_state_o[g*ST_W +: ST_W] = bank_st[g];
  end

  assign legal = (err == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q    <= 1'b1;
      busy_cnt <= '0;
      rrd_cnt  <= '0;
      cmd_q    <= CMD_NOP;
      code_q   <= ERR_NONE;
      ill_q    <= 1'b0;
      err_q    <= 1'b0;
      apf_q    <= 1'b0;
      paf_q    <= 1'b0;
    end else begin
      cke_q <= cke_i;
      cmd_q <= cmd;
      ill_q <= !legal;
      if (!legal) begin
        err_q  <= 1'b1;
        code_q <= err;
      end
      apf_q <= legal && (cmd == CMD_RD || cmd == CMD_WR) && ap_i;
      paf_q <= legal && (cmd == CMD_PRE) && ap_i;

      if (legal && (cmd == CMD_AREF || cmd == CMD_SREF)) busy_cnt <= CNT_W'(T_RC - 1);
      else if (legal && cmd == CMD_MRS)                  busy_cnt <= CNT_W'(T_MRD - 1);
      else if (busy_cnt != '0)                           busy_cnt <= busy_cnt - 1'b1;

      if (legal && cmd == CMD_ACT) rrd_cnt <= CNT_W'(T_RRD - 1);
      else if (rrd_cnt != '0)      rrd_cnt <= rrd_cnt - 1'b1;
    end
  end

  assign cmd_o      = cmd_q;
  assign illegal_o  = ill_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign auto_pre_o = apf_q;
  assign pre_all_o  = paf_q;
  assign busy_o     = (busy_cnt != '0);
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [CMD_W-1:0]          cmd_o,
  input logic                      illegal_o,
  input logic                      err_o,
  input logic [ERR_W-1:0]          err_code_o,
  input logic                      auto_pre_o,
  input logic                      pre_all_o,
  input logic                      busy_o,
  input logic [NUM_BANKS*ST_W-1:0] bank_state_o
);
  logic all_idle, none_live;

  always_comb begin
    all_idle  = 1'b1;
    none_live = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_state_o[i*ST_W +: ST_W] != BK_IDLE) all_idle = 1'b0;
      if (bank_state_o[i*ST_W +: ST_W] inside {BK_ACTIVE, BK_READ, BK_WRITE})
        none_live = 1'b0;
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R11
  ill_flags_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (err_o && err_code_o != ERR_NONE));

  // R7
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> all_idle);

  // R6
  pre_all_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |-> none_live);

  // R5
  auto_pre_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> !illegal_o);

  // R1
  suspend_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_SUSP) |-> !illegal_o);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bk
    // R3
    idle_to_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[g*ST_W +: ST_W] == BK_IDLE) |=>
      (bank_state_o[g*ST_W +: ST_W] inside {BK_IDLE, BK_OPENING}));
  end
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .illegal_o(illegal_o),
  .err_o(err_o), .err_code_o(err_code_o), .auto_pre_o(auto_pre_o),
  .pre_all_o(pre_all_o), .busy_o(busy_o), .bank_state_o(bank_state_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  import sdram_trk_pkg::*;

  localparam int NB = 4;
  localparam logic [2:0] RC_MRS = 3'b000, RC_REF = 3'b001, RC_PRE = 3'b010,
                         RC_ACT = 3'b011, RC_WR  = 3'b100, RC_RD  = 3'b101,
                         RC_BST = 3'b110, RC_NOP = 3'b111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, ap;
  logic [1:0] ba;
  logic [3:0] cmd_o;
  logic [2:0] err_code_o;
  logic illegal_o, err_o, auto_pre_o, pre_all_o, busy_o;
  logic [NB*3-1:0] bank_state_o;

  sdram_cmd_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .ap_i(ap), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .err_o(err_o), .err_code_o(err_code_o),
    .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o), .busy_o(busy_o),
    .bank_state_o(bank_state_o)
  );

  typedef struct {
    cmd_e     cmd;
    logic     ill;
    err_e     code;
    logic     apf;
    logic     paf;
    int       bank;
    bank_st_e st;
    int       busy;
    string    req;
  } exp_t;

  exp_t exp_q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exv);
    end
  endtask

  // driver: one command per edge, expectation queued after the edge
  task automatic step(input logic [2:0] rcw, input logic [1:0] b, input logic a10,
                      input logic ck, input logic csn, input cmd_e ecmd,
                      input logic eill, input err_e ecode, input logic eap,
                      input logic epa, input int ebank, input bank_st_e est,
                      input int ebusy, input string req);
    exp_t e;
    @(negedge clk);
    {ras_n, cas_n, we_n} = rcw;
    ba = b; ap = a10; cke = ck; cs_n = csn;
    @(posedge clk);
    e.cmd = ecmd; e.ill = eill; e.code = ecode; e.apf = eap; e.paf = epa;
    e.bank = ebank; e.st = est; e.busy = ebusy; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic nop(input int ebank, input bank_st_e est, input int ebusy, input string req);
    step(RC_NOP, 2'd0, 1'b0, 1'b1, 1'b0, CMD_NOP, 1'b0, ERR_NONE, 1'b0, 1'b0,
         ebank, est, ebusy, req);
  endtask

  // monitor: compares outputs between edges
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      bit ok;
      e = exp_q.pop_front();
      ok = (cmd_o == e.cmd) && (illegal_o == e.ill) &&
           (!e.ill || err_code_o == e.code) && (auto_pre_o == e.apf) &&
           (pre_all_o == e.paf) &&
           (e.bank < 0 || bank_state_o[e.bank*3 +: 3] == e.st) &&
           (e.busy < 0 || busy_o == e.busy[0]);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s actual cmd=%0d ill=%0b code=%0d ap=%0b pa=%0b st=%h busy=%0b expected cmd=%0d ill=%0b code=%0d ap=%0b pa=%0b bank%0d=%0d busy=%0d",
                 e.req, cmd_o, illegal_o, err_code_o, auto_pre_o, pre_all_o,
                 bank_state_o, busy_o, e.cmd, e.ill, e.code, e.apf, e.paf,
                 e.bank, e.st, e.busy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = RC_NOP;
    ba = 2'd0; ap = 1'b0;
    repeat (3) @(negedge clk);
    // R11 / R1 reset state
    chk(cmd_o == CMD_NOP && !illegal_o && !err_o && !busy_o && bank_state_o == '0,
        "R11 reset", int'(bank_state_o), 0);
    rst_n = 1'b1;

    step(RC_MRS, 0, 0, 1, 0, CMD_MRS, 0, ERR_NONE,  0, 0, -1, BK_IDLE, 1, "R7 mode set");
    step(RC_ACT, 0, 0, 1, 0, CMD_ACT, 1, ERR_BUSY,  0, 0,  0, BK_IDLE, 0, "R7 act while busy");
    step(RC_ACT, 0, 0, 1, 0, CMD_ACT, 0, ERR_NONE,  0, 0,  0, BK_OPENING, -1, "R3 activate");
    step(RC_ACT, 1, 0, 1, 0, CMD_ACT, 1, ERR_RRD,   0, 0,  1, BK_IDLE, -1, "R10 act spacing");
    step(RC_RD,  0, 0, 1, 0, CMD_RD,  1, ERR_BANK_SHUT, 0, 0, 0, BK_ACTIVE, -1, "R4 read too early");
    step(RC_ACT, 0, 0, 1, 0, CMD_ACT, 1, ERR_BANK_OPEN, 0, 0, 0, BK_ACTIVE, -1, "R3 act open bank");
    step(RC_ACT, 1, 0, 1, 0, CMD_ACT, 0, ERR_NONE,  0, 0,  1, BK_OPENING, -1, "R10 act after gap");
    step(RC_RD,  0, 0, 1, 0, CMD_RD,  0, ERR_NONE,  0, 0,  0, BK_READ, -1, "R4 read start");
    nop(1, BK_ACTIVE, -1, "R3 opening done");
    step(RC_RD,  0, 0, 1, 0, CMD_RD,  0, ERR_NONE,  0, 0,  0, BK_READ, -1, "R8 read restart");
    nop(0, BK_READ, -1, "R8 burst extended");
    nop(0, BK_READ, -1, "R4 burst running");
    nop(0, BK_ACTIVE, -1, "R4 burst end");
    step(RC_WR,  1, 1, 1, 0, CMD_WR,  0, ERR_NONE,  1, 0,  1, BK_WRITE, -1, "R5 write auto-pre");
    step(RC_RD,  1, 0, 1, 0, CMD_RD,  1, ERR_AP_LOCK, 0, 0, 1, BK_WRITE, -1, "R9 read locked bank");
    step(RC_BST, 0, 0, 1, 0, CMD_BST, 1, ERR_AP_LOCK, 0, 0, 1, BK_WRITE, -1, "R9 stop locked");
    nop(1, BK_CLOSING, -1, "R5 closing");
    step(RC_PRE, 0, 0, 1, 0, CMD_PRE, 0, ERR_NONE,  0, 0,  0, BK_CLOSING, -1, "R6 single precharge");
    nop(1, BK_IDLE, -1, "R5 idle after close");
    nop(0, BK_IDLE, -1, "R6 idle after T_RP");
    step(RC_REF, 0, 0, 1, 0, CMD_AREF, 0, ERR_NONE, 0, 0, -1, BK_IDLE, 1, "R2 auto refresh");
    for (int i = 0; i < 5; i++) nop(-1, BK_IDLE, -1, "R2 wait");
    nop(-1, BK_IDLE, 1, "R7 still busy");
    step(RC_ACT, 2, 0, 1, 0, CMD_ACT, 1, ERR_BUSY,  0, 0,  2, BK_IDLE, 0, "R7 refresh window");
    step(RC_ACT, 2, 0, 1, 0, CMD_ACT, 0, ERR_NONE,  0, 0,  2, BK_OPENING, -1, "R3 act bank2");
    step(RC_REF, 0, 0, 1, 0, CMD_AREF, 1, ERR_NOT_QUIET, 0, 0, 2, BK_OPENING, -1, "R7 refresh not idle");
    step(RC_PRE, 2, 0, 1, 0, CMD_PRE, 1, ERR_OPENING, 0, 0, 2, BK_ACTIVE, -1, "R12 precharge opening");
    step(RC_ACT, 3, 0, 1, 0, CMD_ACT, 0, ERR_NONE,  0, 0,  3, BK_OPENING, -1, "R10 act bank3");
    nop(3, BK_OPENING, -1, "R3 bank3 opening");
    step(RC_RD,  2, 0, 1, 0, CMD_RD,  0, ERR_NONE,  0, 0,  2, BK_READ, -1, "R4 read bank2");
    step(RC_PRE, 0, 1, 1, 0, CMD_PRE, 0, ERR_NONE,  0, 1,  2, BK_CLOSING, -1, "R6 precharge all");
    nop(3, BK_CLOSING, -1, "R6 bank3 closing");
    nop(3, BK_IDLE, -1, "R6 bank3 idle");
    step(RC_MRS, 0, 0, 1, 1, CMD_DESEL, 0, ERR_NONE, 0, 0, 0, BK_IDLE, 0, "R1 deselect ignored");
    step(RC_REF, 0, 0, 0, 0, CMD_SREF, 0, ERR_NONE, 0, 0, -1, BK_IDLE, 1, "R2 self refresh");
    step(RC_ACT, 0, 0, 0, 0, CMD_SUSP, 0, ERR_NONE, 0, 0, 0, BK_IDLE, -1, "R1 suspend ignores act");
    step(RC_NOP, 0, 0, 1, 0, CMD_SUSP, 0, ERR_NONE, 0, 0, -1, BK_IDLE, -1, "R1 suspend exit");
    nop(-1, BK_IDLE, -1, "R1 nop decode");
    nop(-1, BK_IDLE, -1, "R2 wait");
    nop(-1, BK_IDLE, -1, "R2 wait");
    nop(-1, BK_IDLE, 1, "R2 self refresh busy");
    nop(-1, BK_IDLE, 0, "R2 self refresh done");
    step(RC_BST, 0, 0, 1, 0, CMD_BST, 0, ERR_NONE,  0, 0, -1, BK_IDLE, -1, "R1 burst stop decode");
    step(RC_WR,  0, 0, 1, 0, CMD_WR,  1, ERR_BANK_SHUT, 0, 0, 0, BK_IDLE, -1, "R4 write idle bank");

    repeat (2) @(negedge clk);
    // R11 sticky flag and latest code
    chk(err_o == 1'b1, "R11 sticky", int'(err_o), 1);
    chk(err_code_o == ERR_BANK_SHUT, "R11 last code", int'(err_code_o), int'(ERR_BANK_SHUT));
    done = 1;
    summary();
    $finish;
  end
endmodule